// File: doc/BRIEF.md
# Serial-In Latched Parallel Driver Logic

This block is the control logic of an output driver that takes its channel states over a serial link. A serial bit stream is clocked into a shift register. The last register stage is also driven out as a serial output, so several of these blocks can be chained end to end to build a wider driver. A bank of level-transparent latches copies the register while the load input is high. An active-high blanking input turns every channel off.

Everything runs on one system clock. The external shift clock is treated as a data input: the block samples it and performs one shift on each detected low-to-high transition. A synchronous active-high reset clears the register and the latches. The register width is a parameter with a default of eight channels. The electrical side of a real driver (current sinking, supplies, thermal limits) is not modelled.

Top module: `serial_latch_driver`

## Requirements
- R1: While `rst` is high at a clock edge, and after it is released, the shift register and the latches are all zero, so `drive_on` is 0 and `ser_out` is 0.
- R2: One shift happens for each clock edge at which `shift_clk` is 1 and was 0 at the previous edge. `shift_clk` held high or held low for any number of cycles causes no further shift.
- R3: `ser_out` carries the last stage (stage WIDTH-1). A bit entered on `ser_in` reaches `ser_out` after WIDTH shifts.
- R4: While `load_en` is high, the latches follow the register. `drive_on` (with `blank` low) shows the register contents in the same cycle a shift lands.
- R5: While `load_en` is low, the latches keep their value and further shifting does not change `drive_on`. If `load_en` falls in the same cycle a shift is detected, the latches keep the contents from before that shift.
- R6: While `blank` is high, `drive_on` is all zero. The shift register and the latches are not affected; after `blank` falls, the stored latch value appears again unchanged.
- R7: With `blank` low, `drive_on[i]` is 1 exactly when latch i holds 1.
- R8: Stage 0 is the stage nearest `ser_in` and drives `drive_on[0]`. After WIDTH shifts, the bit shifted in first sits in `drive_on[WIDTH-1]` and the bit shifted in last sits in `drive_on[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_clk | input | 1 | External shift clock, sampled; a rise triggers one shift |
| ser_in | input | 1 | Serial data entering stage 0 |
| load_en | input | 1 | Latch transparency; high lets the latches follow the register |
| blank | input | 1 | High forces every channel off |
| ser_out | output | 1 | Last register stage, for chaining |
| drive_on | output | WIDTH | Per-channel on flags |

## Verification
The case that needs the most care is a shift arriving in the same cycle as the load input changes level. The bench creates two such cases. In one, `load_en` stays high while a shift lands, and `drive_on` must show the new register value in that cycle. In the other, `load_en` falls on the same edge that sees the shift-clock rise, and `drive_on` must keep the value from before the shift. Expected values come from a bench-side model of the register and latches. The bench sweeps every 8-bit pattern through entry with outputs blanked, a load pulse, reveal, a further shift and chain output.

// File: rtl/serial_latch_driver.sv
module serial_latch_driver #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_clk,
  input  logic             ser_in,
  input  logic             load_en,
  input  logic             blank,
  output logic             ser_out,
  output logic [WIDTH-1:0] drive_on
);

  logic             shift_clk_q;
  logic             shift_edge;
  logic [WIDTH-1:0] stage_q, stage_d, hold_q, latch_view;

  assign shift_edge = shift_clk & ~shift_clk_q;
  assign stage_d    = shift_edge ? {stage_q[WIDTH-2:0], ser_in} : stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_clk_q <= 1'b0;
      stage_q     <= '0;
      hold_q      <= '0;
    end else begin
      shift_clk_q <= shift_clk;
      stage_q     <= stage_d;
      if (load_en) hold_q <= stage_d;
    end
  end

  assign latch_view = load_en ? stage_q : hold_q;
  assign drive_on   = blank ? '0 : latch_view;
  assign ser_out    = stage_q[WIDTH-1];

  // R2
  shift_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_edge |=> $stable(stage_q));

  // R3
  ser_advance_chk: assert property (@(posedge clk) disable iff (rst)
    shift_edge |=> ser_out == $past(stage_q[WIDTH-2]));

  // R4
  load_follow_chk: assert property (@(posedge clk) disable iff (rst)
    load_en |=> hold_q == stage_q);

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(hold_q));

  // R6
  blank_off_chk: assert property (@(posedge clk) disable iff (rst)
    blank |-> drive_on == '0);

endmodule

// File: tb/serial_latch_driver_bench.sv
module serial_latch_driver_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_clk = 1'b0;
  logic ser_in = 1'b0;
  logic load_en = 1'b0;
  logic blank = 1'b0;
  logic ser_out;
  logic [W-1:0] drive_on;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] m_sr = '0;
  logic [W-1:0] m_latch = '0;

  serial_latch_driver #(.WIDTH(W)) u_serial_latch_driver (
    .clk(clk), .rst(rst), .shift_clk(shift_clk), .ser_in(ser_in),
    .load_en(load_en), .blank(blank), .ser_out(ser_out), .drive_on(drive_on));

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // drives a rise at a negedge; the shift lands on the next posedge; returns at a negedge
  task automatic shift_bit(input logic b, input int hold);
    @(negedge clk);
    ser_in = b;
    shift_clk = 1'b1;
    for (int i = 0; i < hold; i++) @(negedge clk);
    shift_clk = 1'b0;
    m_sr = {m_sr[W-2:0], b};
    if (load_en) m_latch = m_sr;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 check("R1 drive_on in reset", drive_on, '0);
    check("R1 ser_out in reset", W'(ser_out), '0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1 check("R1 drive_on after reset", drive_on, '0);

    // R2: held-high shift clock gives one shift only
    load_en = 1'b1;
    shift_bit(1'b1, 5);
    #1 check("R2 single shift on long high", drive_on, m_sr);
    repeat (4) @(negedge clk);
    #1 check("R2 no shift while low", drive_on, W'(1));

    // R4: shift with strobe high, output follows same cycle as the shift lands
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      ser_in = i[0];
      shift_clk = 1'b1;
      @(posedge clk);
      #1 m_sr = {m_sr[W-2:0], ser_in};
      check("R4 transparent same cycle", drive_on, m_sr);
      @(negedge clk);
      shift_clk = 1'b0;
    end
    m_latch = m_sr;

    // R5: strobe falls on the same edge a rise is detected
    @(negedge clk);
    ser_in = ~m_sr[0];
    shift_clk = 1'b1;
    load_en = 1'b0;
    @(negedge clk);
    shift_clk = 1'b0;
    m_sr = {m_sr[W-2:0], ser_in};
    #1 check("R5 strobe fall with shift keeps old", drive_on, m_latch);

    // full sweep of patterns
    for (int p = 0; p < (1 << W); p++) begin
      logic [W-1:0] pat;
      pat = W'(p);
      blank = 1'b1;
      for (int k = W - 1; k >= 0; k--) shift_bit(pat[k], 1);
      #1 check("R6 blank forces off", drive_on, '0);
      check("R3 ser_out last stage", W'(ser_out), W'(pat[W-1]));
      @(negedge clk);
      load_en = 1'b1;
      #1 check("R6 blank during load", drive_on, '0);
      @(negedge clk);
      load_en = 1'b0;
      m_latch = m_sr;
      blank = 1'b0;
      #1 check("R8 bit order after load", drive_on, pat);
      check("R7 on equals latch", drive_on, m_latch);
      shift_bit(~pat[0], 1);
      #1 check("R5 shift with strobe low", drive_on, m_latch);
      check("R3 chain advances", W'(ser_out), W'(pat[W-2]));
      @(negedge clk);
      blank = 1'b1;
      @(negedge clk);
      blank = 1'b0;
      #1 check("R6 latch kept across blank", drive_on, m_latch);
    end

    summary();
    $finish;
  end
endmodule